// File: doc/BRIEF.md
# DMA Request/Acknowledge Handshake Engine

This block is the device-side engine for DMA data movement on a parallel disk interface. The device core hands it a command made of a start pulse, a word count and a direction. Once the buffer FIFO can supply or accept a word, the engine raises its request line. It then waits for the host's active-low acknowledge and moves one 16-bit word for each completed host strobe. The read strobe pulls words out of the FIFO and the write strobe pushes words into it.

The request line has three states. While a command is active and the device is selected, the line is driven high or low. Otherwise it is released, shown here as a drive enable next to the value. The request is only withdrawn while acknowledge is held, and it is raised again while words remain and the FIFO is ready. The engine also enforces some protocol rules. A chip select seen while acknowledge is held is reported as a protocol error, and the strobe that comes with it is dropped. A strobe for the wrong direction is ignored. When the last word has moved and the host lets go of acknowledge, the engine ends the command with a done pulse.

Top module: `dma_hs_engine`

## Requirements
- R1: After reset the request line is released (`dmarq_oe`=0, `dmarq_out`=0), the data bus is not driven, `done` and `proto_err` are 0, and neither FIFO strobe is active.
- R2: A start with a nonzero length, accepted while the engine is idle and selected with the FIFO ready, leads to `dmarq_oe`=1 one clock after the start is sampled and to `dmarq_out`=1 one clock after that.
- R3: Once raised, the request stays high in every cycle in which acknowledge (`host_dmack_n`) is high; it is only ever negated in a cycle in which acknowledge is low.
- R4: With `cmd_to_host`=1 (device to host), `host_data_out` equals `rx_data` and `host_data_oe`=1 while acknowledge is low, both chip selects are high and `host_rd_n` is low. Each rising edge of `host_rd_n` under those conditions pops exactly one word (`rx_pop` for one cycle).
- R5: With `cmd_to_host`=0 (host to device), the word on `host_data_in` while `host_wr_n` is low is captured, and it is pushed to `tx_data` with a one-cycle `tx_push` at the rising edge of `host_wr_n`.
- R6: The clock edge that completes the last word negates the request, and the line stays driven low while acknowledge is held. The first clock edge that sees acknowledge high then gives `done`=1 for exactly one cycle and releases the line.
- R7: If the FIFO is not ready (`rx_valid`=0 on reads, `tx_ready`=0 on writes) while acknowledge is held and words remain, the request is negated at the next edge but stays driven. It is raised again at the first edge at which the FIFO is ready.
- R8: While `dev_sel`=0 the request line is released (`dmarq_oe`=0) even during a command, and it is driven again as soon as `dev_sel` returns to 1.
- R9: A chip select (either bit of `host_cs_n` low) while a command is active and acknowledge is low sets `proto_err` for the next cycle, and any strobe completing in that cycle moves no word.
- R10: A strobe of the opposite direction (the write strobe during a read command, or the read strobe during a write command) moves no word and leaves the request unchanged.
- R11: A start with length 0, or a start while a command is active, is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_start | input | 1 | One-cycle command start from the device core |
| cmd_len | input | LEN_W | Number of 16-bit words in the command |
| cmd_to_host | input | 1 | 1 = device-to-host (read), 0 = host-to-device (write) |
| dev_sel | input | 1 | Device currently selected |
| host_cs_n | input | 2 | Host chip selects, active low |
| host_dmack_n | input | 1 | Host DMA acknowledge, active low |
| host_rd_n | input | 1 | Host read strobe, active low |
| host_wr_n | input | 1 | Host write strobe, active low |
| host_data_in | input | DATA_W | Data bus value driven by the host |
| host_data_out | output | DATA_W | Data bus value driven by the device |
| host_data_oe | output | 1 | Device drives the data bus |
| dmarq_out | output | 1 | DMA request level |
| dmarq_oe | output | 1 | DMA request drive enable (0 = released) |
| rx_data | input | DATA_W | FIFO head word for reads |
| rx_valid | input | 1 | FIFO holds a word for the host |
| rx_pop | output | 1 | Pop the FIFO head |
| tx_data | output | DATA_W | Word written by the host |
| tx_ready | input | 1 | FIFO can accept a word |
| tx_push | output | 1 | Push tx_data into the FIFO |
| done | output | 1 | One-cycle command completion pulse |
| proto_err | output | 1 | Chip select seen during acknowledge |

## Verification
Each result has a fixed latency. Drive enables and the read data follow their inputs within the same cycle. FIFO pops and pushes fire in the cycle in which a strobe's rising edge is first sampled. The request level, `done` and `proto_err` appear one clock edge after the condition that causes them, and the start-to-request path takes two edges. The bench changes inputs on falling clock edges and reads outputs at later falling edges. It counts whole clock cycles between a stimulus and the check for each of these latencies, so every comparison lands in the cycle in which the result is due. A small FIFO model in the bench logs every pop and push, which lets dropped or ignored strobes be checked as unchanged counts.

// File: rtl/dma_hs_pkg.sv
package dma_hs_pkg;
   typedef enum logic {
      DIR_TO_DEV  = 1'b0,
      DIR_TO_HOST = 1'b1
   } dma_dir_e;

   localparam int STRB_RD  = 0;
   localparam int STRB_WR  = 1;
   localparam int STRB_NUM = 2;
endpackage

// File: rtl/dma_strobe_det.sv
module dma_strobe_det #(
   parameter int NUM = 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NUM-1:0] strb_n,
   output logic [NUM-1:0] rise
);
   initial begin
      if (NUM < 1) $error("dma_strobe_det: NUM must be at least 1");
   end

   for (genvar g = 0; g < NUM; g++) begin : g_strb
      logic prev_n;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) prev_n <= 1'b1;
         else        prev_n <= strb_n[g];
      end
      assign rise[g] = strb_n[g] & ~prev_n;

      assert_rise_after_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
         rise[g] |-> $past(strb_n[g]) == 1'b0);
   end
endmodule

// File: rtl/dma_word_cnt.sv
module dma_word_cnt #(
   parameter int LEN_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [LEN_W-1:0] load_val,
   input  logic             dec,
   output logic             is_zero,
   output logic             is_last
);
   initial begin
      if (LEN_W < 1) $error("dma_word_cnt: LEN_W must be at least 1");
   end

   localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

   logic [LEN_W-1:0] remain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        remain <= '0;
      else if (load)                     remain <= load_val;
      else if (dec && remain != '0)      remain <= remain - ONE;
   end

   assign is_zero = (remain == '0);
   assign is_last = (remain == ONE);

   assert_count_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (dec && !load && !is_zero) |=> remain == $past(remain) - ONE);
   assert_count_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!dec && !load) |=> $stable(remain));
endmodule

// File: rtl/dma_req_ctrl.sv
module dma_req_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic active,
   input  logic cnt_zero,
   input  logic cnt_last,
   input  logic fifo_ok,
   input  logic ack_on,
   input  logic word_done,
   output logic req
);
   logic req_clr;
   logic req_set;

   assign req_clr = req & ack_on & ((word_done & cnt_last) | ~fifo_ok);
   assign req_set = ~req & active & ~cnt_zero & fifo_ok & ~word_done;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       req <= 1'b0;
      else if (req_clr) req <= 1'b0;
      else if (req_set) req <= 1'b1;
   end

   assert_hold_until_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (req && !ack_on) |=> req);
   assert_no_req_without_words_R6: assert property (@(posedge clk) disable iff (!rst_n)
      req |-> !cnt_zero);
   assert_reraise_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!req && active && !cnt_zero && fifo_ok && !word_done) |=> req);
endmodule

// File: rtl/dma_hs_engine.sv
module dma_hs_engine #(
   parameter int DATA_W = 16,
   parameter int LEN_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_start,
   input  logic [LEN_W-1:0]  cmd_len,
   input  logic              cmd_to_host,
   input  logic              dev_sel,
   input  logic [1:0]        host_cs_n,
   input  logic              host_dmack_n,
   input  logic              host_rd_n,
   input  logic              host_wr_n,
   input  logic [DATA_W-1:0] host_data_in,
   output logic [DATA_W-1:0] host_data_out,
   output logic              host_data_oe,
   output logic              dmarq_out,
   output logic              dmarq_oe,
   input  logic [DATA_W-1:0] rx_data,
   input  logic              rx_valid,
   output logic              rx_pop,
   output logic [DATA_W-1:0] tx_data,
   input  logic              tx_ready,
   output logic              tx_push,
   output logic              done,
   output logic              proto_err
);
   import dma_hs_pkg::*;

   initial begin
      if (DATA_W != 16) $error("dma_hs_engine: DMA words must be 16 bits");
      if (LEN_W < 1)    $error("dma_hs_engine: LEN_W must be at least 1");
   end

   logic              active;
   dma_dir_e          dir;
   logic [DATA_W-1:0] wr_hold;
   logic [STRB_NUM-1:0] strb_rise;
   logic              ack_on, cs_idle, strobe_ok;
   logic              rd_done, wr_done, word_done;
   logic              fifo_ok, start_ok, finish;
   logic              cnt_zero, cnt_last, req;

   assign ack_on    = ~host_dmack_n;
   assign cs_idle   = &host_cs_n;
   assign strobe_ok = active & ack_on & cs_idle;
   assign fifo_ok   = (dir == DIR_TO_HOST) ? rx_valid : tx_ready;
   assign start_ok  = cmd_start & ~active & (cmd_len != '0);
   assign finish    = active & cnt_zero & ~ack_on;

   dma_strobe_det #(.NUM(STRB_NUM)) u_strb (
      .clk    (clk),
      .rst_n  (rst_n),
      .strb_n ({host_wr_n, host_rd_n}),
      .rise   (strb_rise)
   );

   assign rd_done   = strb_rise[STRB_RD] & strobe_ok & (dir == DIR_TO_HOST) & rx_valid;
   assign wr_done   = strb_rise[STRB_WR] & strobe_ok & (dir == DIR_TO_DEV)  & tx_ready;
   assign word_done = rd_done | wr_done;

   dma_word_cnt #(.LEN_W(LEN_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (start_ok),
      .load_val (cmd_len),
      .dec      (word_done),
      .is_zero  (cnt_zero),
      .is_last  (cnt_last)
   );

   dma_req_ctrl u_req (
      .clk       (clk),
      .rst_n     (rst_n),
      .active    (active),
      .cnt_zero  (cnt_zero),
      .cnt_last  (cnt_last),
      .fifo_ok   (fifo_ok),
      .ack_on    (ack_on),
      .word_done (word_done),
      .req       (req)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active    <= 1'b0;
         dir       <= DIR_TO_DEV;
         done      <= 1'b0;
         proto_err <= 1'b0;
      end else begin
         done      <= finish;
         proto_err <= active & ack_on & ~cs_idle;
         if (start_ok) begin
            active <= 1'b1;
            dir    <= dma_dir_e'(cmd_to_host);
         end else if (finish) begin
            active <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          wr_hold <= '0;
      else if (!host_wr_n) wr_hold <= host_data_in;
   end

   assign host_data_out = rx_data;
   assign host_data_oe  = strobe_ok & (dir == DIR_TO_HOST) & ~host_rd_n;
   assign rx_pop        = rd_done;
   assign tx_push       = wr_done;
   assign tx_data       = wr_hold;
   assign dmarq_oe      = active & dev_sel;
   assign dmarq_out     = req & dmarq_oe;

   assert_single_dir_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(rx_pop && tx_push));
   assert_err_drops_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_idle) |-> !(rx_pop || tx_push));
   assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   assert_done_releases_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !dmarq_oe);
   assert_drop_only_on_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(req) && $past(active)) |-> $past(ack_on));
   assert_busy_start_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (active && cmd_start && !finish) |=> active && $stable(dir));
endmodule

// File: tb/sim_dma_hs_engine.sv
module sim_dma_hs_engine;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_start = 1'b0;
   logic [15:0] cmd_len = '0;
   logic        cmd_to_host = 1'b0;
   logic        dev_sel = 1'b1;
   logic [1:0]  host_cs_n = 2'b11;
   logic        host_dmack_n = 1'b1;
   logic        host_rd_n = 1'b1;
   logic        host_wr_n = 1'b1;
   logic [15:0] host_data_in = '0;
   logic [15:0] host_data_out;
   logic        host_data_oe, dmarq_out, dmarq_oe;
   logic [15:0] rx_data;
   logic        rx_valid, rx_pop;
   logic [15:0] tx_data;
   logic        tx_ready = 1'b1;
   logic        tx_push, done, proto_err;

   int errors = 0;
   int checks = 0;
   int rd_idx = 0;
   int rx_fill = 0;
   int push_cnt = 0;
   logic [15:0] push_log [8];

   always #5 clk = ~clk;

   dma_hs_engine u0 (
      .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_len(cmd_len),
      .cmd_to_host(cmd_to_host), .dev_sel(dev_sel), .host_cs_n(host_cs_n),
      .host_dmack_n(host_dmack_n), .host_rd_n(host_rd_n), .host_wr_n(host_wr_n),
      .host_data_in(host_data_in), .host_data_out(host_data_out),
      .host_data_oe(host_data_oe), .dmarq_out(dmarq_out), .dmarq_oe(dmarq_oe),
      .rx_data(rx_data), .rx_valid(rx_valid), .rx_pop(rx_pop), .tx_data(tx_data),
      .tx_ready(tx_ready), .tx_push(tx_push), .done(done), .proto_err(proto_err)
   );

   assign rx_data  = 16'hA000 + 16'(rd_idx);
   assign rx_valid = (rd_idx < rx_fill);

   always @(posedge clk) begin
      if (rx_pop) rd_idx <= rd_idx + 1;
      if (tx_push) begin
         push_log[push_cnt % 8] <= tx_data;
         push_cnt <= push_cnt + 1;
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic start_cmd(input logic [15:0] len, input logic to_host);
      cmd_len = len; cmd_to_host = to_host; cmd_start = 1'b1;
      tick(1);
      cmd_start = 1'b0;
   endtask

   task automatic host_read(input string req);
      host_rd_n = 1'b0;
      tick(1);
      chk(req, {31'd0, host_data_oe}, 32'd1);
      chk(req, {16'd0, host_data_out}, 32'hA000 + 32'(rd_idx));
      host_rd_n = 1'b1;
      tick(1);
   endtask

   task automatic host_write(input logic [15:0] d);
      host_wr_n = 1'b0; host_data_in = d;
      tick(1);
      host_wr_n = 1'b1;
      tick(1);
      host_data_in = '0;
   endtask

   task automatic finish_cmd(input string req);
      chk(req, {30'd0, dmarq_oe, dmarq_out}, 32'b10);
      host_dmack_n = 1'b1;
      tick(1);
      chk(req, {30'd0, done, dmarq_oe}, 32'b10);
      tick(1);
      chk(req, {31'd0, done}, 32'd0);
   endtask

   task automatic t_reset;
      chk("R1", {27'd0, dmarq_oe, dmarq_out, host_data_oe, done, proto_err}, 32'd0);
      chk("R1", {30'd0, rx_pop, tx_push}, 32'd0);
   endtask

   task automatic t_read_basic;
      int p0;
      rx_fill = rd_idx + 2;
      start_cmd(16'd2, 1'b1);
      chk("R2", {30'd0, dmarq_oe, dmarq_out}, 32'b10);
      tick(1);
      chk("R2", {30'd0, dmarq_oe, dmarq_out}, 32'b11);
      tick(4);
      chk("R3", {31'd0, dmarq_out}, 32'd1);
      host_dmack_n = 1'b0;
      chk("R4", {31'd0, host_data_oe}, 32'd0);
      p0 = rd_idx;
      host_read("R4");
      chk("R4", 32'(rd_idx - p0), 32'd1);
      chk("R4", {31'd0, dmarq_out}, 32'd1);
      host_read("R4");
      chk("R4", 32'(rd_idx - p0), 32'd2);
      chk("R6", {31'd0, dmarq_out}, 32'd0);
      finish_cmd("R6");
   endtask

   task automatic t_write_basic;
      int c0;
      c0 = push_cnt;
      start_cmd(16'd2, 1'b0);
      tick(1);
      chk("R2", {31'd0, dmarq_out}, 32'd1);
      host_dmack_n = 1'b0;
      host_write(16'h1234);
      chk("R5", 32'(push_cnt - c0), 32'd1);
      chk("R5", {16'd0, push_log[c0 % 8]}, 32'h1234);
      host_write(16'hBEEF);
      chk("R5", 32'(push_cnt - c0), 32'd2);
      chk("R5", {16'd0, push_log[(c0 + 1) % 8]}, 32'hBEEF);
      finish_cmd("R6");
   endtask

   task automatic t_fifo_stall;
      rx_fill = rd_idx + 1;
      start_cmd(16'd3, 1'b1);
      tick(1);
      host_dmack_n = 1'b0;
      host_read("R7");
      tick(1);
      chk("R7", {30'd0, dmarq_oe, dmarq_out}, 32'b10);
      rx_fill = rd_idx + 2;
      tick(1);
      chk("R7", {31'd0, dmarq_out}, 32'd1);
      host_read("R7");
      host_read("R7");
      finish_cmd("R7");
   endtask

   task automatic t_tx_stall;
      tx_ready = 1'b1;
      start_cmd(16'd2, 1'b0);
      tick(1);
      host_dmack_n = 1'b0;
      host_write(16'h0055);
      tx_ready = 1'b0;
      tick(1);
      chk("R7", {30'd0, dmarq_oe, dmarq_out}, 32'b10);
      tx_ready = 1'b1;
      tick(1);
      chk("R7", {31'd0, dmarq_out}, 32'd1);
      host_write(16'h0066);
      finish_cmd("R7");
   endtask

   task automatic t_deselect;
      rx_fill = rd_idx + 1;
      start_cmd(16'd1, 1'b1);
      tick(1);
      dev_sel = 1'b0;
      tick(1);
      chk("R8", {30'd0, dmarq_oe, dmarq_out}, 32'b00);
      dev_sel = 1'b1;
      tick(1);
      chk("R8", {30'd0, dmarq_oe, dmarq_out}, 32'b11);
      host_dmack_n = 1'b0;
      host_read("R8");
      finish_cmd("R8");
   endtask

   task automatic t_cs_error;
      int p0, c0;
      rx_fill = rd_idx + 1;
      start_cmd(16'd1, 1'b1);
      tick(1);
      host_dmack_n = 1'b0;
      p0 = rd_idx;
      host_cs_n = 2'b10; host_rd_n = 1'b0;
      tick(1);
      host_rd_n = 1'b1;
      tick(1);
      chk("R9", {31'd0, proto_err}, 32'd1);
      chk("R9", 32'(rd_idx - p0), 32'd0);
      host_cs_n = 2'b11;
      tick(1);
      chk("R9", {31'd0, proto_err}, 32'd0);
      c0 = push_cnt;
      host_write(16'h7777);
      chk("R10", 32'(push_cnt - c0), 32'd0);
      chk("R10", 32'(rd_idx - p0), 32'd0);
      chk("R10", {31'd0, dmarq_out}, 32'd1);
      host_read("R9");
      chk("R9", 32'(rd_idx - p0), 32'd1);
      finish_cmd("R9");
   endtask

   task automatic t_ignored_starts;
      int c0;
      start_cmd(16'd0, 1'b0);
      tick(2);
      chk("R11", {30'd0, dmarq_oe, dmarq_out}, 32'b00);
      start_cmd(16'd1, 1'b0);
      start_cmd(16'd5, 1'b1);
      chk("R11", {31'd0, dmarq_out}, 32'd1);
      host_dmack_n = 1'b0;
      c0 = push_cnt;
      host_write(16'h0ACE);
      chk("R11", 32'(push_cnt - c0), 32'd1);
      finish_cmd("R11");
   endtask

   initial begin
      #2000000;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      tick(2);
      t_reset();
      rst_n = 1'b1;
      tick(1);
      t_read_basic();
      t_write_basic();
      t_fifo_stall();
      t_tx_stall();
      t_deselect();
      t_cs_error();
      t_ignored_starts();
      tick(2);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule